// File: doc/BRIEF.md
# Shifting Flip-Flop FIFO Queue

This block is a first-in first-out queue of `DEPTH` entries, each `WIDTH` bits wide, built entirely from flip-flops. It keeps no read or write pointer. The oldest entry always sits in position 0 and drives the data output directly. A new flit lands in the lowest unoccupied position, right behind the youngest stored flit. Every accepted pop moves all stored entries one position toward the front.

Per-position occupancy bits are exported so that a neighbouring stage can see how full the queue is without a counter. The queue serves as the shifting counterpart of a pointer-addressed register-file FIFO. It has the same push/pop/full/empty contract, and it can be dropped into the same place to compare the two.

Top module: `shiftq_fifo`

## Requirements
- R1: While `rst_n` is low and after its release, `slot_valid_o` is all zero, `empty_o` is 1 and `full_o` is 0.
- R2: Flits leave in the order they were accepted, and `dout_o` always shows the flit in position 0, which is the oldest stored flit.
- R3: A push without a pop on a queue holding N < DEPTH flits writes `din_i` into position N, so `slot_valid_o` goes from the value 2^N-1 to 2^(N+1)-1. Occupied positions always form one contiguous run starting at bit 0.
- R4: A pop without a push on a non-empty queue holding N flits moves the flit in position i+1 into position i for every i. Afterwards `slot_valid_o` equals 2^(N-1)-1.
- R5: A push and a pop in the same cycle on a queue holding N flits, with 1 <= N < DEPTH, shift the contents forward and write `din_i` into position N-1. The occupancy is unchanged.
- R6: A push while `full_o` is 1 is ignored: with no pop the contents and occupancy are unchanged, and with a pop only the pop takes effect.
- R7: A pop while `empty_o` is 1 is ignored and leaves the occupancy bits unchanged. A push in that same cycle is still accepted into position 0.
- R8: `empty_o` is the inverse of `slot_valid_o[0]` and `full_o` equals `slot_valid_o[DEPTH-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Request to store `din_i` |
| din_i | input | WIDTH | Flit to store |
| pop_i | input | 1 | Request to discard the flit in position 0 |
| dout_o | output | WIDTH | Flit in position 0 (oldest) |
| empty_o | output | 1 | No flit stored |
| full_o | output | 1 | All positions occupied |
| slot_valid_o | output | DEPTH | Occupancy bit per position, bit 0 at the front |

## Verification
The embedded properties check on every cycle several invariants of the occupancy vector. It must stay a contiguous run from bit 0, grow by exactly one on a lone accepted push and keep its value on a combined push and pop. It must not move on a push into a full queue or a pop from an empty one. Each storage position must also either hold its flit or take its rear neighbour's flit on a shift. The properties cannot see that the flit written lands at the right position after a combined operation, or that order survives long mixed sequences. Those are shown only by the bench's sweep over every occupancy and every push/pop combination and its long pseudo-random stream against an arithmetic model.

// File: rtl/shiftq_pkg.sv
package shiftq_pkg;

    // Accepted operation in a cycle, {push accepted, pop accepted}
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } shiftq_op_e;

endpackage

// File: rtl/shiftq_slot.sv
module shiftq_slot #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic [WIDTH-1:0] next_i,
    output logic [WIDTH-1:0] data_o
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.data = din_i;
        end else if (shift_i) begin
            st_d.data = next_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;

    // R4: a position that is neither written nor shifted keeps its flit
    a_r4_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !shift_i) |=> $stable(data_o));

    // R4: a shift without a write takes the rear neighbour's flit
    a_r4_slot_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !wr_i) |=> (data_o == $past(next_i)));

endmodule

// File: rtl/shiftq_ctrl.sv
module shiftq_ctrl
    import shiftq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             shift_o,
    output logic [DEPTH-1:0] wr_sel_o,
    output logic [DEPTH-1:0] valid_o
);

    typedef struct packed {
        logic [DEPTH-1:0] valid;
    } ctrl_st_t;

    ctrl_st_t         st_d, st_q;
    logic             push_ok, pop_ok;
    logic [DEPTH-1:0] after_shift;
    logic [DEPTH-1:0] behind_used;
    logic [DEPTH-1:0] wr_sel;
    shiftq_op_e       op;

    always_comb begin
        push_ok     = push_i && !st_q.valid[DEPTH-1];
        pop_ok      = pop_i && st_q.valid[0];
        op          = shiftq_op_e'({push_ok, pop_ok});
        after_shift = pop_ok ? (st_q.valid >> 1) : st_q.valid;
        // a free position whose front neighbour is occupied (or position 0)
        behind_used = {after_shift[DEPTH-2:0], 1'b1};
        wr_sel      = '0;
        st_d        = st_q;
        case (op)
            OP_PUSH, OP_BOTH: begin
                wr_sel     = ~after_shift & behind_used;
                st_d.valid = after_shift | wr_sel;
            end
            OP_POP: begin
                st_d.valid = after_shift;
            end
            default: begin
                st_d.valid = st_q.valid;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_o  = pop_ok;
    assign wr_sel_o = wr_sel;
    assign valid_o  = st_q.valid;

    // R3: occupancy is always a contiguous run from position 0
    a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid_o & (valid_o + 1'b1)) == '0));

    // R3: a lone accepted push adds exactly one occupied position
    a_r3_grow_one: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !valid_o[DEPTH-1]) |=>
        ($countones(valid_o) == $countones($past(valid_o)) + 1));

    // R5: push and pop together on a non-full, non-empty queue keep occupancy
    a_r5_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && valid_o[0] && !valid_o[DEPTH-1]) |=> $stable(valid_o));

    // R6: a push into a full queue with no pop changes nothing
    a_r6_full_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && valid_o[DEPTH-1]) |=> $stable(valid_o));

    // R7: a pop from an empty queue with no push changes nothing
    a_r7_empty_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !valid_o[0]) |=> $stable(valid_o));

endmodule

// File: rtl/shiftq_fifo.sv
module shiftq_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [DEPTH-1:0] slot_valid_o
);

    localparam int LAST = DEPTH - 1;

    logic             shift;
    logic [DEPTH-1:0] wr_sel;
    logic [DEPTH-1:0] valid;
    logic [WIDTH-1:0] slot_data [DEPTH];
    logic [WIDTH-1:0] slot_next [DEPTH];

    shiftq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .shift_o  (shift),
        .wr_sel_o (wr_sel),
        .valid_o  (valid)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == LAST) begin : g_tail
            assign slot_next[i] = '0;
        end else begin : g_body
            assign slot_next[i] = slot_data[i+1];
        end

        shiftq_slot #(.WIDTH(WIDTH)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_sel[i]),
            .shift_i (shift),
            .din_i   (din_i),
            .next_i  (slot_next[i]),
            .data_o  (slot_data[i])
        );
    end

    assign dout_o       = slot_data[0];
    assign empty_o      = !valid[0];
    assign full_o       = valid[LAST];
    assign slot_valid_o = valid;

    // R2: the front flit stays put while no pop is accepted
    a_r2_front_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_o && !pop_i) |=> (dout_o == $past(dout_o)));

    // R4: an accepted lone pop brings the second flit to the front
    a_r4_front_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && slot_valid_o[1]) |=> (dout_o == $past(slot_data[1])));

endmodule

// File: tb/shiftq_fifo_test.sv
module shiftq_fifo_test;

    localparam int D = 4;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push = 1'b0;
    logic         pop = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         empty, full;
    logic [D-1:0] sv;

    int checks = 0;
    int failures = 0;

    logic [W-1:0] mq [D];
    int           mc = 0;

    shiftq_fifo #(.DEPTH(D), .WIDTH(W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push),
        .din_i        (din),
        .pop_i        (pop),
        .dout_o       (dout),
        .empty_o      (empty),
        .full_o       (full),
        .slot_valid_o (sv)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare every output against the arithmetic model
    task automatic compare(input string tag);
        logic [D-1:0] ev;
        ev = D'((1 << mc) - 1);
        check({tag, " occupancy"}, 32'(sv), 32'(ev));
        check("R8 empty", 32'(empty), 32'(mc == 0));
        check("R8 full", 32'(full), 32'(mc == D));
        if (mc > 0) check({tag, " R2 front"}, 32'(dout), 32'(mq[0]));
    endtask

    task automatic step(input logic p, input logic q, input logic [W-1:0] d, input string tag);
        bit pok, uok;
        @(negedge clk);
        push = p; pop = q; din = d;
        @(posedge clk);
        #1;
        pok = q && (mc > 0);
        uok = p && (mc < D);
        if (pok) begin
            for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
            mc--;
        end
        if (uok) begin
            mq[mc] = d;
            mc++;
        end
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push = 1'b0; pop = 1'b0;
        @(posedge clk); #1;
        check("R1 valid in reset", 32'(sv), 32'd0);
        check("R1 empty in reset", 32'(empty), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        mc = 0;
        @(posedge clk); #1;
        check("R1 valid after reset", 32'(sv), 32'd0);
        check("R1 empty after reset", 32'(empty), 32'd1);
        check("R1 full after reset", 32'(full), 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        string       tag;
        do_reset();

        // sweep every starting occupancy against every push/pop combination
        for (int occ = 0; occ <= D; occ++) begin
            for (int op = 0; op < 4; op++) begin
                do_reset();
                for (int k = 0; k < occ; k++) step(1'b1, 1'b0, W'(occ * 16 + k + 1), "R3 fill");
                case (op)
                    0: tag = "R3 idle";
                    1: tag = (occ == 0) ? "R7 pop empty" : "R4 pop";
                    2: tag = (occ == D) ? "R6 push full" : "R3 push";
                    default: tag = (occ == 0) ? "R7 pop+push empty" :
                                   (occ == D) ? "R6 push+pop full" : "R5 push+pop";
                endcase
                step(op[1], op[0], 8'hA5, tag);
                while (mc > 0) step(1'b0, 1'b1, '0, "R2 drain");
                step(1'b0, 1'b1, '0, "R7 pop after drain");
            end
        end

        // long mixed stream with a pseudo-random pattern
        do_reset();
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], lfsr[3] & (lfsr[7] | lfsr[9]), lfsr[15:8], "R2 stream");
        end
        lfsr = 16'h1D0F;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & lfsr[4], lfsr[2] | lfsr[6], lfsr[11:4], "R4 stream");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule